// File: doc/BRIEF.md
# Timer/Counter with Shared Watchdog Prescaler

This block is an 8-bit up-counter with two clock sources. It counts either every cycle of the internal instruction clock or edges of an external pin, and the edge polarity of the pin is programmable. The block contains one power-of-two prescaler, and software assigns it at run time to one of two paths. On the timer path it slows the counter down. On the watchdog path it divides an incoming watchdog tick stream before that stream leaves the block as a watchdog time-out pulse. The path that does not own the prescaler bypasses it.

The count events pass through a two-stage synchronizer before they reach the counter. When the counter wraps from all-ones to zero, it sets a sticky overflow flag. The interrupt output is that flag gated by an enable bit. A sleep input freezes the timer.

Software reaches the block through a small register port. The port has a write strobe, a 2-bit address, write data, and combinational read data.

Top module: `tw_timer_wdt`

## Requirements
- R1: After reset, the control register (address 1) reads FFh, the interrupt register (address 2) reads 00h, the counter (address 0) reads 00h, and address 3 reads 00h. Both outputs are low.
- R2: Control fields: bit 0 selects the source (1 = external pin, 0 = internal clock), bit 1 inverts the pin, bit 2 assigns the prescaler (1 = watchdog, 0 = timer), and bits 5:3 hold the rate. With the internal source and the prescaler on the watchdog, the counter advances by one on every cycle. A counter write blocks the next two increments, so the written value is first incremented on the third rising edge after the write edge.
- R3: With the prescaler on the timer, the counter advances once every 2^(rate+1) internal cycles. A counter write clears the prescaler. After the write edge plus K edges (K >= 2), the count is W + floor((K-2)/2^(rate+1)) mod 256.
- R4: With the external source, control bit 1 = 0 counts rising pin edges and bit 1 = 1 counts falling pin edges. The opposite edge has no effect.
- R5: A counted pin edge that is set up before clock edge P is visible in the counter after edge P+3 and not after edge P+2.
- R6: The counter wrapping from FFh to 00h sets the flag, interrupt register bit 0, on the same edge. The flag stays set until software writes a 0 to that bit.
- R7: The interrupt output is high exactly when the flag and the enable bit (interrupt register bit 1) are both set.
- R8: While the sleep input is high, the counter holds and no overflow flag is set.
- R9: With the prescaler on the watchdog, the watchdog output gives one pulse per 2^rate watchdog ticks, one cycle after the tick that completes the period. The watchdog clear strobe restarts the count.
- R10: With the prescaler on the timer, each watchdog tick appears on the watchdog output one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal instruction clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 counter, 1 control, 2 interrupt) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational |
| ext_clk | input | 1 | External count pin |
| wdt_tick | input | 1 | Watchdog oscillator tick, one cycle wide |
| wdt_clear | input | 1 | Watchdog clear strobe |
| sleep | input | 1 | Freezes the timer while high |
| tmr_irq | output | 1 | Overflow interrupt (flag and enable) |
| wdt_out | output | 1 | Watchdog time-out pulse after division |

## Verification
Register writes take effect on the next rising edge. A counter write has its first possible increment on the third edge after the write edge. A counted pin edge shows in the counter three edges after it is captured. The overflow flag rises on the wrap edge, and the watchdog output follows its tick by one edge. The bench drives and samples on falling edges and counts the rising edges between stimulus and check. For the pin path it checks one edge before each result is due as well as on the edge it is due. The random runs compute the expected count from the edge count and the division ratio.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
   localparam int DW = 8;
   localparam int AW = 2;

   localparam logic [AW-1:0] ADDR_CNT  = 2'd0;
   localparam logic [AW-1:0] ADDR_CTRL = 2'd1;
   localparam logic [AW-1:0] ADDR_IRQ  = 2'd2;

   localparam int IRQ_FLAG_BIT = 0;
   localparam int IRQ_EN_BIT   = 1;

   typedef struct packed {
      logic [1:0] spare;
      logic [2:0] rate;
      logic       psel_wdt;
      logic       edge_inv;
      logic       src_ext;
   } tw_ctrl_t;
endpackage

// File: rtl/tw_edge_src.sv
`timescale 1ns/1ps
module tw_edge_src (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic inv,
   output logic evt
);
   logic cap_q, prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q  <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         cap_q  <= pin ^ inv;
         prev_q <= cap_q;
      end
   end

   assign evt = cap_q & ~prev_q;

   AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) evt |=> !evt); // R4
endmodule

// File: rtl/tw_prescaler.sv
`timescale 1ns/1ps
module tw_prescaler #(
   parameter int PW = 8,
   parameter int RW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick_in,
   input  logic [RW-1:0] rate,
   output logic          tap_tmr,
   output logic          tap_wdt
);
   localparam int IW = $clog2(PW + 1);

   initial begin
      AST_PW_FITS: assert (PW >= (1 << RW)) else $fatal(1, "prescaler too narrow for rate field");
   end

   logic [PW-1:0] pre_q;
   logic [PW:0]   ones_lo;
   logic [IW-1:0] idx_t, idx_w;

   assign ones_lo[0] = 1'b1;
   for (genvar i = 0; i < PW; i++) begin : g_chain
      assign ones_lo[i+1] = ones_lo[i] & pre_q[i];
   end

   assign idx_t = IW'(rate) + IW'(1);
   assign idx_w = IW'(rate);

   assign tap_tmr = tick_in & ones_lo[idx_t];
   assign tap_wdt = tick_in & ones_lo[idx_w];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (clr)     pre_q <= '0;
      else if (tick_in) pre_q <= pre_q + PW'(1);
   end

   AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (pre_q == '0)); // R9
endmodule

// File: rtl/tw_sync.sv
`timescale 1ns/1ps
module tw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic d,
   output logic q
);
   initial begin
      AST_STAGES_MIN: assert (STAGES >= 1) else $fatal(1, "synchronizer needs a stage");
   end

   logic [STAGES-1:0] sh_q;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   sh_q <= '0;
         else if (clr) sh_q <= '0;
         else          sh_q <= d;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   sh_q <= '0;
         else if (clr) sh_q <= '0;
         else          sh_q <= {sh_q[STAGES-2:0], d};
      end
   end

   assign q = sh_q[STAGES-1];

   AST_SYNC_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) clr |=> !q); // R2
endmodule

// File: rtl/tw_timer_wdt.sv
`timescale 1ns/1ps
module tw_timer_wdt
   import tw_pkg::*;
#(
   parameter int CW          = 8,
   parameter int PW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          ext_clk,
   input  logic          wdt_tick,
   input  logic          wdt_clear,
   input  logic          sleep,
   output logic          tmr_irq,
   output logic          wdt_out
);
   localparam int RW = 3;

   initial begin
      AST_CW_BUS: assert (CW <= DW && CW >= 1) else $fatal(1, "counter wider than bus");
   end

   tw_ctrl_t      ctrl_q;
   logic [CW-1:0] cnt_q;
   logic          flag_q, ien_q, wdt_q;
   logic          wr_cnt, wr_ctrl, wr_irq;
   logic          ext_evt, src_evt, tmr_src;
   logic          pre_in, pre_clr, tap_t, tap_w;
   logic          tmr_raw, inc_req, inc;

   assign wr_cnt  = bus_we && (bus_addr == ADDR_CNT);
   assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);
   assign wr_irq  = bus_we && (bus_addr == ADDR_IRQ);

   tw_edge_src u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ext_clk),
      .inv   (ctrl_q.edge_inv),
      .evt   (ext_evt)
   );

   assign src_evt = ctrl_q.src_ext ? ext_evt : 1'b1;
   assign tmr_src = src_evt & ~sleep;

   assign pre_in  = ctrl_q.psel_wdt ? wdt_tick  : tmr_src;
   assign pre_clr = ctrl_q.psel_wdt ? wdt_clear : wr_cnt;

   tw_prescaler #(.PW(PW), .RW(RW)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (pre_clr),
      .tick_in (pre_in),
      .rate    (ctrl_q.rate),
      .tap_tmr (tap_t),
      .tap_wdt (tap_w)
   );

   assign tmr_raw = ctrl_q.psel_wdt ? tmr_src : tap_t;

   tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wr_cnt),
      .d     (tmr_raw),
      .q     (inc_req)
   );

   assign inc = inc_req & ~sleep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (wr_cnt) cnt_q <= bus_wdata[CW-1:0];
      else if (inc)    cnt_q <= cnt_q + CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '1;
      else if (wr_ctrl) ctrl_q <= tw_ctrl_t'(bus_wdata);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         ien_q  <= 1'b0;
      end else begin
         if (inc && (&cnt_q)) flag_q <= 1'b1;
         else if (wr_irq)     flag_q <= bus_wdata[IRQ_FLAG_BIT];
         if (wr_irq)          ien_q  <= bus_wdata[IRQ_EN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wdt_q <= 1'b0;
      else        wdt_q <= ctrl_q.psel_wdt ? tap_w : wdt_tick;
   end

   assign wdt_out = wdt_q;
   assign tmr_irq = flag_q & ien_q;

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_CNT:  bus_rdata = DW'(cnt_q);
         ADDR_CTRL: bus_rdata = ctrl_q;
         ADDR_IRQ: begin
            bus_rdata[IRQ_FLAG_BIT] = flag_q;
            bus_rdata[IRQ_EN_BIT]   = ien_q;
         end
         default:   bus_rdata = '0;
      endcase
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) !wr_cnt |=> (cnt_q == $past(cnt_q) || cnt_q == CW'($past(cnt_q) + CW'(1)))); // R2
   AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (sleep && !wr_cnt) |=> $stable(cnt_q)); // R8
   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (inc && (&cnt_q) && !wr_cnt) |=> (flag_q && cnt_q == '0)); // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flag_q && !wr_irq) |=> flag_q); // R6
   AST_WDT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n) (!ctrl_q.psel_wdt && !wr_ctrl && wdt_tick) |=> wdt_out); // R10
endmodule

// File: tb/tw_timer_wdt_test.sv
`timescale 1ns/1ps
module tw_timer_wdt_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       ext_clk = 1'b0;
   logic       wdt_tick = 1'b0;
   logic       wdt_clear = 1'b0;
   logic       sleep = 1'b0;
   logic       tmr_irq, wdt_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tw_timer_wdt uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
      .wdt_tick(wdt_tick), .wdt_clear(wdt_clear), .sleep(sleep),
      .tmr_irq(tmr_irq), .wdt_out(wdt_out)
   );

   function automatic logic [7:0] ctrl_val(input logic [2:0] rate, input logic psel,
                                           input logic inv, input logic src);
      return {2'b00, rate, psel, inv, src};
   endfunction

   function automatic logic [7:0] exp_count(input logic [7:0] w, input int k, input int n);
      return 8'(int'(w) + (k - 2) / n);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wdt_run(input int m, output int pulses);
      pulses = 0;
      wdt_tick = 1'b1;
      for (int i = 0; i < m + 3; i++) begin
         @(negedge clk);
         pulses += int'(wdt_out);
         if (i == m - 1) wdt_tick = 1'b0;
      end
   endtask

   task automatic wdt_clr;
      @(negedge clk);
      wdt_clear = 1'b1;
      @(negedge clk);
      wdt_clear = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d, v, w;
      int p, k, n;
      logic [2:0] rate;
      logic psel;
      void'($urandom(32'd4242));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, read before any edge
      rd(2'd1, d); check("R1 ctrl", d, 8'hFF);
      rd(2'd2, d); check("R1 irq reg", d, 8'h00);
      rd(2'd0, d); check("R1 counter", d, 8'h00);
      rd(2'd3, d); check("R1 addr3", d, 8'h00);
      check("R1 outputs", {6'd0, tmr_irq, wdt_out}, 8'h00);

      // R2 internal source, prescaler on watchdog: +1 per cycle after two blocked edges
      wr(2'd1, ctrl_val(3'd0, 1'b1, 1'b0, 1'b0));
      rd(2'd1, d); check("R2 ctrl readback", d, 8'h04);
      wr(2'd0, 8'h40);
      @(negedge clk); rd(2'd0, d); check("R2 blocked edge1", d, 8'h40);
      @(negedge clk); rd(2'd0, d); check("R2 blocked edge2", d, 8'h40);
      @(negedge clk); rd(2'd0, d); check("R2 first inc", d, 8'h41);
      repeat (5) @(negedge clk); rd(2'd0, d); check("R2 steady", d, 8'h46);

      // R3 directed: rate 0 on timer, ratio 2
      wr(2'd1, ctrl_val(3'd0, 1'b0, 1'b0, 1'b0));
      wr(2'd0, 8'h10);
      repeat (3) @(negedge clk); rd(2'd0, d); check("R3 K=3", d, 8'h10);
      @(negedge clk); rd(2'd0, d); check("R3 K=4", d, 8'h11);

      // R3 / R2 random: rate, assignment, run length; watchdog ticks as noise
      for (int it = 0; it < 40; it++) begin
         rate = 3'($urandom % 8);
         psel = 1'($urandom % 2);
         n = psel ? 1 : (1 << (int'(rate) + 1));
         w = 8'($urandom % 256);
         k = 2 + int'($urandom % (3 * n + 20));
         wr(2'd1, ctrl_val(rate, psel, 1'b0, 1'b0));
         wr(2'd0, w);
         for (int j = 0; j < k; j++) begin
            wdt_tick = 1'($urandom % 2);
            @(negedge clk);
         end
         wdt_tick = 1'b0;
         rd(2'd0, d);
         check(psel ? "R2 random" : "R3 random", d, exp_count(w, k, n));
      end

      // R4/R5 external, rising edges
      ext_clk = 1'b0;
      wr(2'd1, ctrl_val(3'd0, 1'b1, 1'b0, 1'b1));
      repeat (4) @(negedge clk);
      wr(2'd0, 8'h20);
      repeat (4) @(negedge clk);
      ext_clk = 1'b1;
      repeat (3) @(negedge clk); rd(2'd0, d); check("R5 rise not yet at P+2", d, 8'h20);
      @(negedge clk); rd(2'd0, d); check("R5 rise at P+3", d, 8'h21);
      repeat (4) @(negedge clk);
      ext_clk = 1'b0;
      repeat (6) @(negedge clk); rd(2'd0, d); check("R4 fall ignored when bit1=0", d, 8'h21);

      // R4/R5 external, falling edges
      wr(2'd1, ctrl_val(3'd0, 1'b1, 1'b1, 1'b1));
      repeat (6) @(negedge clk);
      wr(2'd0, 8'h30);
      repeat (4) @(negedge clk);
      ext_clk = 1'b1;
      repeat (6) @(negedge clk); rd(2'd0, d); check("R4 rise ignored when bit1=1", d, 8'h30);
      ext_clk = 1'b0;
      repeat (3) @(negedge clk); rd(2'd0, d); check("R5 fall not yet at P+2", d, 8'h30);
      @(negedge clk); rd(2'd0, d); check("R4 fall counted", d, 8'h31);

      // R6/R7 overflow flag and interrupt gating
      wr(2'd1, ctrl_val(3'd0, 1'b1, 1'b0, 1'b0));
      wr(2'd2, 8'h00);
      wr(2'd0, 8'hFE);
      repeat (3) @(negedge clk);
      rd(2'd0, d); check("R6 at FF", d, 8'hFF);
      rd(2'd2, d); check("R6 flag clear before wrap", d, 8'h00);
      @(negedge clk);
      rd(2'd0, d); check("R6 wrapped", d, 8'h00);
      rd(2'd2, d); check("R6 flag set on wrap", d, 8'h01);
      check("R7 masked", {7'd0, tmr_irq}, 8'h00);
      repeat (20) @(negedge clk);
      rd(2'd2, d); check("R6 flag sticky", d, 8'h01);
      wr(2'd2, 8'h03);
      check("R7 enabled irq", {7'd0, tmr_irq}, 8'h01);
      wr(2'd2, 8'h02);
      rd(2'd2, d); check("R6 software clear", d, 8'h02);
      check("R7 irq drops", {7'd0, tmr_irq}, 8'h00);

      // R8 sleep freezes counter, no overflow
      wr(2'd0, 8'hFD);
      sleep = 1'b1;
      rd(2'd0, v);
      repeat (30) @(negedge clk);
      rd(2'd0, d); check("R8 counter held", d, v);
      rd(2'd2, d); check("R8 no flag in sleep", d, 8'h02);
      sleep = 1'b0;
      repeat (12) @(negedge clk);
      rd(2'd2, d); check("R8 resumes and wraps", d, 8'h03);
      wr(2'd2, 8'h00);

      // R9 watchdog division
      wr(2'd1, ctrl_val(3'd0, 1'b1, 1'b0, 1'b0));
      wdt_clr; wdt_run(5, p); check("R9 rate0", 8'(p), 8'd5);
      wr(2'd1, ctrl_val(3'd3, 1'b1, 1'b0, 1'b0));
      wdt_clr; wdt_run(24, p); check("R9 rate3", 8'(p), 8'd3);
      wr(2'd1, ctrl_val(3'd7, 1'b1, 1'b0, 1'b0));
      wdt_clr; wdt_run(384, p); check("R9 rate7", 8'(p), 8'd3);
      wr(2'd1, ctrl_val(3'd3, 1'b1, 1'b0, 1'b0));
      wdt_clr; wdt_run(7, p); check("R9 partial", 8'(p), 8'd0);
      wdt_clr; wdt_run(7, p); check("R9 clear restarts", 8'(p), 8'd0);
      wdt_run(1, p); check("R9 completes period", 8'(p), 8'd1);

      // R10 prescaler on timer: watchdog ticks pass straight through
      wr(2'd1, ctrl_val(3'd5, 1'b0, 1'b0, 1'b0));
      wdt_run(10, p); check("R10 bypass", 8'(p), 8'd10);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule